// File: doc/BRIEF.md
# Programmable Post-Scale Clock Divider

This block is one output channel of a clock synthesis stage. It divides a fast source clock by a programmable integer and produces a divided clock with a chosen duty cycle. The block has two duty modes. The balanced mode keeps the output high for half of the period. This holds for odd ratios too, because a falling-edge flop supplies the extra half cycle. The custom mode sets the high time as a whole number of source cycles.

The source clock comes from one of eight equally spaced phase taps of the fast clock. Each tap is one eighth of a period later than the one before it. The chosen tap therefore sets the output's phase offset. A cascade select replaces the tap with an external clock, normally the output of another channel, so that chained channels reach larger overall ratios. A chip instantiates several of these channels side by side.

New settings take effect only at the boundary of an output period. Illegal settings are clamped and raise a sticky error flag.

Top module: `postscale_div`

## Requirements
- R1: While `rst` is high, `clk_out` and `err` are both 0.
- R2: In balanced mode (`duty_even`=1) with an even ratio N, the output period is N source cycles and the high time is N/2 source cycles.
- R3: In balanced mode with an odd ratio N of 3 or more, the output period is N source cycles. The high time is exactly N/2 source cycles, an odd number of half cycles, and the extra half cycle comes from the falling edge.
- R4: A ratio of 1 passes the source clock straight to `clk_out`, in either mode.
- R5: In custom mode (`duty_even`=0) with a legal ratio N from 2 to 256, the output period is N source cycles and the high time is `high_val` source cycles, where `high_val` lies from 1 to N-1.
- R6: A `div_val` of 0, or one above the mode's limit (512 in balanced mode, 256 in custom mode), is replaced by that limit and sets `err`.
- R7: In custom mode with a ratio of 2 or more, a `high_val` of 0 is treated as 1. A `high_val` of N or more is treated as N-1. Both cases set `err`.
- R8: Once set, `err` stays at 1 until reset, even when legal settings follow. Legal settings never set `err`.
- R9: With `casc_sel`=0, the source is `ph_clk[phase_sel]`. The first rising edge of `clk_out` after reset therefore lies `phase_sel` eighths of a fast period after a rising edge of `ph_clk[0]`.
- R10: With `casc_sel`=1, the counter is clocked by `casc_clk`, and the ratio applies to that clock's period.
- R11: Settings are sampled only at the first source edge after reset and at the end of each output period. A period already in progress always completes with its old period and high time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Asynchronous reset, active high |
| ph_clk | input | 8 | Eight phase taps of the fast clock, tap k lags tap 0 by k/8 of a period |
| casc_clk | input | 1 | External clock used when cascading |
| casc_sel | input | 1 | 1 selects `casc_clk` as the source, 0 selects a phase tap |
| phase_sel | input | 3 | Index of the phase tap |
| duty_even | input | 1 | 1 selects balanced duty, 0 selects custom high time |
| div_val | input | 10 | Division ratio |
| high_val | input | 9 | High time in source cycles (custom mode) |
| clk_out | output | 1 | Divided clock |
| err | output | 1 | Sticky flag for clamped settings |

## Verification
The settings reload and the start of a new output pulse share the same source edge. When the reload brings an illegal value, the clamp and the error update also fall on that edge. The bench provokes this by changing the ratio and duty a short time after an output rising edge. That pulse must still end with the old timing, and the next pulse must show the new timing with no short fragment in between. A scoreboard compares every measured period and high time against values computed from the settings. For clamp cases, the flag is read once the clamped periods have been observed.

// File: rtl/postscale_div.sv
module postscale_div #(
  parameter int DIV_W      = 10,
  parameter int MAX_EVEN   = 512,
  parameter int MAX_UNEVEN = 256,
  parameter int PHASES     = 8
) (
  input  logic                       rst,
  input  logic [PHASES-1:0]          ph_clk,
  input  logic                       casc_clk,
  input  logic                       casc_sel,
  input  logic [$clog2(PHASES)-1:0]  phase_sel,
  input  logic                       duty_even,
  input  logic [DIV_W-1:0]           div_val,
  input  logic [DIV_W-2:0]           high_val,
  output logic                       clk_out,
  output logic                       err
);

  logic             clk_src;
  logic [DIV_W-1:0] cnt, eff_div, eff_hi;
  logic             eff_odd, eff_even, byp, q_pos, q_neg;
  logic [DIV_W-1:0] lim, nd, nh, hi_ext;
  logic             div_bad, hi_bad;

  assign clk_src = casc_sel ? casc_clk : ph_clk[phase_sel];

  assign lim     = duty_even ? DIV_W'(MAX_EVEN) : DIV_W'(MAX_UNEVEN);
  assign div_bad = (div_val == '0) || (div_val > lim);
  assign nd      = div_bad ? lim : div_val;
  assign hi_ext  = {1'b0, high_val};
  assign hi_bad  = !duty_even && (nd != DIV_W'(1)) && ((hi_ext == '0) || (hi_ext >= nd));

  always_comb begin
    if (duty_even)            nh = nd >> 1;
    else if (hi_ext == '0)    nh = DIV_W'(1);
    else if (hi_ext >= nd)    nh = nd - DIV_W'(1);
    else                      nh = hi_ext;
  end

  always_ff @(posedge clk_src or posedge rst) begin
    if (rst) begin
      cnt      <= '0;
      eff_div  <= DIV_W'(1);
      eff_hi   <= '0;
      eff_odd  <= 1'b0;
      eff_even <= 1'b1;
      byp      <= 1'b0;
      q_pos    <= 1'b0;
      err      <= 1'b0;
    end else if (cnt == eff_div - DIV_W'(1)) begin
      cnt      <= '0;
      eff_div  <= nd;
      eff_hi   <= nh;
      eff_odd  <= duty_even & nd[0] & (nd != DIV_W'(1));
      eff_even <= duty_even;
      byp      <= (nd == DIV_W'(1));
      q_pos    <= (nd != DIV_W'(1));
      err      <= err | div_bad | hi_bad;
    end else begin
      cnt      <= cnt + 1'b1;
      q_pos    <= (cnt + 1'b1) < eff_hi;
    end
  end

  always_ff @(negedge clk_src or posedge rst) begin
    if (rst) q_neg <= 1'b0;
    else     q_neg <= q_pos;
  end

  assign clk_out = byp ? clk_src : (q_pos | (eff_odd & q_neg));

  // R11: the count never leaves the active period
  p_cnt_range_r11: assert property (@(posedge clk_src) disable iff (rst)
    cnt < eff_div);

  // R11: a pulse only begins at the first count of a period
  p_pulse_start_r11: assert property (@(posedge clk_src) disable iff (rst)
    $rose(q_pos) |-> cnt == '0);

  // R6: the active ratio stays inside the mode's limit
  p_div_limit_r6: assert property (@(posedge clk_src) disable iff (rst)
    (eff_div != '0) && (eff_div <= (eff_even ? DIV_W'(MAX_EVEN) : DIV_W'(MAX_UNEVEN))));

  // R7: the active high time is legal whenever a real division runs
  p_hi_limit_r7: assert property (@(posedge clk_src) disable iff (rst)
    (!byp && eff_div != DIV_W'(1)) |-> (eff_hi != '0 && eff_hi < eff_div));

  // R8: the error flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk_src) disable iff (rst)
    err |=> err);

  // R4: pass-through only with a unit ratio
  p_bypass_r4: assert property (@(posedge clk_src) disable iff (rst)
    byp |-> eff_div == DIV_W'(1));

  // R2: balanced mode keeps half the period high
  p_even_half_r2: assert property (@(posedge clk_src) disable iff (rst)
    (eff_even && !byp && eff_div != DIV_W'(1)) |-> eff_hi == (eff_div >> 1));

endmodule

// File: tb/sim_postscale_div.sv
`timescale 1ps/1ps
module sim_postscale_div;
  localparam int TCLK = 5000;

  logic       rst = 1'b1;
  logic [7:0] ph;
  logic [2:0] st = 3'd0;
  logic       casc_clk = 1'b0;
  logic       casc_sel = 1'b0;
  logic [2:0] phase_sel = 3'd0;
  logic       duty_even = 1'b1;
  logic [9:0] div_val = 10'd4;
  logic [8:0] high_val = 9'd0;
  logic       dout, err;

  int  total = 0, fails = 0;
  bit  done = 0, have = 0;
  longint rise_t = 0, fall_t = 0;
  longint exp_per[$], exp_hi[$];

  postscale_div u0 (
    .rst(rst), .ph_clk(ph), .casc_clk(casc_clk), .casc_sel(casc_sel),
    .phase_sel(phase_sel), .duty_even(duty_even), .div_val(div_val),
    .high_val(high_val), .clk_out(dout), .err(err)
  );

  initial forever #625 st = st + 3'd1;
  always_comb for (int i = 0; i < 8; i++) ph[i] = (3'(st - 3'(i)) < 3'd4);
  initial forever #10000 casc_clk = ~casc_clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial forever begin
    @(negedge dout);
    fall_t = $time;
  end

  initial forever begin
    @(posedge dout);
    if (rst) have = 0;
    else begin
      if (have && exp_per.size() > 0) begin
        longint p, h;
        p = exp_per.pop_front();
        h = exp_hi.pop_front();
        chk($time - rise_t == p, "R2/R3/R4/R5/R10/R11 period", $time - rise_t, p);
        chk(fall_t - rise_t == h, "R2/R3/R4/R5/R10/R11 high", fall_t - rise_t, h);
      end
      have = 1;
      rise_t = $time;
    end
  end

  task automatic push(input int dv, input int hv, input bit ev, input longint base, input int n);
    int lim, d, h;
    longint per, hp;
    lim = ev ? 512 : 256;
    d = (dv == 0 || dv > lim) ? lim : dv;
    per = d * base;
    if (d == 1) hp = base / 2;
    else if (ev) hp = d * (base / 2);
    else begin
      h = (hv == 0) ? 1 : (hv >= d ? d - 1 : hv);
      hp = h * base;
    end
    repeat (n) begin
      exp_per.push_back(per);
      exp_hi.push_back(hp);
    end
  endtask

  task automatic drain();
    while (exp_per.size() != 0) @(posedge dout);
  endtask

  task automatic start(input int dv, input int hv, input bit ev, input int phs, input bit cs);
    longint t;
    rst = 1'b1;
    have = 0;
    div_val = 10'(dv); high_val = 9'(hv); duty_even = ev;
    phase_sel = 3'(phs); casc_sel = cs;
    #7300;
    chk(dout == 1'b0, "R1 clk_out in reset", longint'(dout), 0);
    chk(err == 1'b0, "R1 err in reset", longint'(err), 0);
    rst = 1'b0;
    @(posedge dout);
    t = $time;
    if (cs) chk(t % 20000 == 10000, "R10 cascade edge", t % 20000, 10000);
    else chk(t % TCLK == phs * 625, "R9 phase offset", t % TCLK, phs * 625);
  endtask

  task automatic change(input int dv, input int hv, input bit ev,
                        input int odv, input int ohv, input bit oev, input int n);
    #1000;
    div_val = 10'(dv); high_val = 9'(hv); duty_even = ev;
    push(odv, ohv, oev, TCLK, 1);
    push(dv, hv, ev, TCLK, n);
    drain();
  endtask

  initial begin
    // R2 even ratio, balanced
    start(4, 0, 1, 0, 0);  push(4, 0, 1, TCLK, 3);  drain();
    // R3 odd ratios, balanced
    start(5, 0, 1, 0, 0);  push(5, 0, 1, TCLK, 3);  drain();
    start(3, 0, 1, 0, 0);  push(3, 0, 1, TCLK, 3);  drain();
    // R4 unit ratio
    start(1, 0, 1, 0, 0);  push(1, 0, 1, TCLK, 3);  drain();
    start(1, 7, 0, 0, 0);  push(1, 7, 0, TCLK, 2);  drain();
    // R5 custom duty
    start(6, 2, 0, 0, 0);  push(6, 2, 0, TCLK, 3);  drain();
    chk(err == 1'b0, "R8 legal settings leave err clear", longint'(err), 0);
    // R11 mid-period change: old period completes, then new timing
    change(4, 0, 1, 6, 2, 0, 3);
    change(7, 3, 0, 4, 0, 1, 2);
    chk(err == 1'b0, "R8 err after legal changes", longint'(err), 0);
    // R6 ratio clamp, balanced
    start(600, 0, 1, 0, 0);  push(600, 0, 1, TCLK, 2);  drain();
    chk(err == 1'b1, "R6 err after ratio clamp", longint'(err), 1);
    // R8 sticky across legal settings
    change(4, 0, 1, 600, 0, 1, 2);
    chk(err == 1'b1, "R8 err sticky", longint'(err), 1);
    // R6 ratio clamp, custom (too large and zero)
    start(300, 100, 0, 0, 0);  push(300, 100, 0, TCLK, 2);  drain();
    chk(err == 1'b1, "R6 err custom clamp", longint'(err), 1);
    start(0, 3, 0, 0, 0);  push(0, 3, 0, TCLK, 1);  drain();
    chk(err == 1'b1, "R6 err zero ratio", longint'(err), 1);
    // R7 high-time clamp
    start(8, 9, 0, 0, 0);  push(8, 9, 0, TCLK, 2);  drain();
    chk(err == 1'b1, "R7 err high too large", longint'(err), 1);
    start(8, 0, 0, 0, 0);  push(8, 0, 0, TCLK, 2);  drain();
    chk(err == 1'b1, "R7 err high zero", longint'(err), 1);
    // R6 boundary: limit itself is legal
    start(512, 0, 1, 0, 0);  push(512, 0, 1, TCLK, 2);  drain();
    chk(err == 1'b0, "R6 limit ratio legal", longint'(err), 0);
    // R9 phase taps
    start(6, 0, 1, 3, 0);  push(6, 0, 1, TCLK, 2);  drain();
    start(5, 0, 1, 6, 0);  push(5, 0, 1, TCLK, 2);  drain();
    // R10 cascade source
    start(3, 0, 1, 0, 1);  push(3, 0, 1, 20000, 2);  drain();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #600_000_000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", exp_per.size(), 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule